// File: doc/BRIEF.md
# Strided 2D Array Read-Address Generator

This block produces the stream of read addresses for one two-dimensional array of ROWS by COLS elements held row-major in a block RAM. A single start pulse launches a run. The block then steps through every position (i,j) of the result array in row-major order and issues one source address per clock. The address depends on the chosen whole-array transform: strided section, shift with padding, cyclic rotate, tiling replicate, transpose or plain identity.

A result position can land outside the source array in the section or shift transform. In that case the block raises a pad flag in place of an address, and the downstream datapath substitutes its constant default value. All wrap-around arithmetic runs on counters that step with the walk, so no divider is needed and the address rate never drops below one per cycle. Only one transform applies per run. The RAM, the datapath and the loading of parameters lie outside the block.

Top module: `strided_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, and whenever addr_valid is low, addr_out is 0 and addr_valid, pad_flag and done are low.
- R2: A start pulse seen while idle makes addr_valid rise on the second clock edge after the edge that sampled start. addr_valid then stays high for exactly ROWS*COLS consecutive cycles, and done is high for exactly one cycle, the cycle right after the last valid address.
- R3: Addresses follow result positions in row-major order. Each address equals source_row*COLS + source_col and is below ROWS*COLS.
- R4: Mode code 0 (section) maps result (i,j) to source (row_base + row_stride*i, col_base + col_stride*j). If that row is at least ROWS, or that column is at least COLS, pad_flag is raised.
- R5: Mode code 1 (shift) maps result (i,j) to source (i - row_shift, j - col_shift), with both shifts signed. When either index is negative or past the array, pad_flag is high and addr_out is 0.
- R6: Mode code 2 (rotate) maps result (i,j) to source ((i - row_shift) mod ROWS, (j - col_shift) mod COLS) for shifts strictly between minus and plus the extent. It never pads.
- R7: Mode code 3 (replicate) maps result (i,j) to source (i mod row_tile, j mod col_tile), for tiles from 1 up to the extent. It never pads.
- R8: Mode code 4 (transpose) uses a result array of COLS rows by ROWS columns and maps result (i,j) to source (j,i).
- R9: Mode and parameters are captured with an accepted start. A start pulse, or a change of mode or parameters, while a run is in progress does not alter the current run's addresses and does not launch a further run.
- R10: Mode codes 5, 6 and 7 map result (i,j) to source (i,j).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run (accepted only while idle) |
| mode | input | 3 | Transform selector |
| row_base | input | IW | Section start row |
| col_base | input | IW | Section start column |
| row_stride | input | IW | Section row step |
| col_stride | input | IW | Section column step |
| row_shift | input | IW+1 | Signed row offset for shift and rotate |
| col_shift | input | IW+1 | Signed column offset for shift and rotate |
| row_tile | input | IW | Replicate tile height |
| col_tile | input | IW | Replicate tile width |
| addr_out | output | AGW | Linear source address |
| addr_valid | output | 1 | Address or pad slot present |
| pad_flag | output | 1 | Position falls outside the source array |
| done | output | 1 | One-cycle end-of-run pulse |

IW is the width that holds max(ROWS, COLS). AGW is clog2(ROWS*COLS).

## Verification
The bench checks every transform over its whole parameter range on a non-square 4 by 6 array, with expected addresses worked out arithmetically. The shift sweep covers every row offset from -4 to 4 against every column offset from -6 to 6. This separates the edge comparisons on both sides and on both axes, and confirms that a padded slot carries address 0. The rotate sweep uses all in-range positive and negative offsets, and the replicate sweep uses every tile size; together they exercise each wrap point of the running counters. Section runs mix zero, unit and large strides, so both in-range and overflowing source rows and columns occur. The transpose run tells the swapped result shape apart from the identity codes. One run is disturbed midway by a new start and new parameters, to show that the captured values hold and no extra run follows.

// File: rtl/agen_pkg.sv
// Shared encodings for the strided address generator.
// Assumes: mode codes are fixed by the register interface outside the block.
package agen_pkg;

    typedef enum logic [2:0] {
        AG_SECTION   = 3'd0,
        AG_SHIFT     = 3'd1,
        AG_ROTATE    = 3'd2,
        AG_REPLICATE = 3'd3,
        AG_TRANSPOSE = 3'd4
    } ag_mode_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_LOAD,
        WK_RUN,
        WK_FLUSH
    } wk_state_e;

endpackage

// File: rtl/agen_walk.sv
// Run control and result-index walker.
// Walks (row_idx, col_idx) in row-major order over the result shape. The shape
// is COLS x ROWS when swap is set (transpose), else ROWS x COLS.
// Assumes: swap is stable from the LOAD cycle to the end of the run.
module agen_walk
    import agen_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 6,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          swap,
    output logic          accept,
    output logic          load,
    output logic          run,
    output logic          flush,
    output logic [IW-1:0] row_idx,
    output logic [IW-1:0] col_idx,
    output logic          row_last,
    output logic          col_last
);

    localparam logic [IW-1:0] R_END = IW'(ROWS - 1);
    localparam logic [IW-1:0] C_END = IW'(COLS - 1);

    wk_state_e     state;
    logic [IW-1:0] row_end;
    logic [IW-1:0] col_end;

    // Decode the state and the end-of-line conditions.
    always_comb begin
        row_end  = swap ? C_END : R_END;
        col_end  = swap ? R_END : C_END;
        accept   = start && (state == WK_IDLE);
        load     = (state == WK_LOAD);
        run      = (state == WK_RUN);
        flush    = (state == WK_FLUSH);
        row_last = (row_idx == row_end);
        col_last = (col_idx == col_end);
    end

    // Sequence idle -> load -> run -> flush -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WK_IDLE;
        end else begin
            unique case (state)
                WK_IDLE:  if (start) state <= WK_LOAD;
                WK_LOAD:  state <= WK_RUN;
                WK_RUN:   if (row_last && col_last) state <= WK_FLUSH;
                WK_FLUSH: state <= WK_IDLE;
                default:  state <= WK_IDLE;
            endcase
        end
    end

    // Step the result indices, column fastest.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            row_idx <= '0;
            col_idx <= '0;
        end else if (run) begin
            if (col_last) begin
                col_idx <= '0;
                if (!row_last) row_idx <= row_idx + 1'b1;
            end else begin
                col_idx <= col_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/agen_axis.sv
// Source-index unit for one array dimension of extent EXT.
// Keeps running counters for the section, rotate and replicate maps so that no
// multiply or divide is needed. Shift is worked out directly from the result index.
// Assumes: |ofs| < EXT for rotate, 1 <= tile <= EXT for replicate.
module agen_axis
    import agen_pkg::*;
#(
    parameter int EXT = 4,
    parameter int IW  = 3,
    localparam int OW = IW + 1,
    localparam int AW = 2 * IW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode,
    input  logic [IW-1:0]        base,
    input  logic [IW-1:0]        stride,
    input  logic [IW-1:0]        tile,
    input  logic signed [OW-1:0] ofs,
    input  logic                 clear,
    input  logic                 step,
    input  logic [IW-1:0]        idx,
    input  logic [IW-1:0]        swap_idx,
    output logic [IW-1:0]        src,
    output logic                 oob
);

    localparam logic [IW-1:0] EXT_M1 = IW'(EXT - 1);
    localparam logic [AW-1:0] EXT_A  = AW'(EXT);
    localparam logic [OW-1:0] EXT_O  = OW'(EXT);

    logic [AW-1:0]        acc;
    logic [IW-1:0]        rot;
    logic [IW-1:0]        rep;
    logic signed [OW:0]   ofs_x;
    logic signed [OW:0]   diff;
    logic signed [OW:0]   rot_init;

    // Signed shift difference and rotate starting point (-ofs mod EXT).
    always_comb begin
        ofs_x    = {ofs[OW-1], ofs};
        diff     = $signed({2'b00, idx}) - ofs_x;
        rot_init = (ofs_x <= 0) ? -ofs_x : ($signed({1'b0, EXT_O}) - ofs_x);
    end

    // Running counters: reload on clear, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            rot <= '0;
            rep <= '0;
        end else if (clear) begin
            acc <= {{(AW-IW){1'b0}}, base};
            rot <= rot_init[IW-1:0];
            rep <= '0;
        end else if (step) begin
            acc <= acc + {{(AW-IW){1'b0}}, stride};
            rot <= (rot == EXT_M1) ? '0 : rot + 1'b1;
            rep <= (rep == tile - 1'b1) ? '0 : rep + 1'b1;
        end
    end

    // Select the source index and the out-of-range flag for the mode.
    always_comb begin
        src = idx;
        oob = 1'b0;
        case (mode)
            AG_SECTION: begin
                src = acc[IW-1:0];
                oob = (acc >= EXT_A);
            end
            AG_SHIFT: begin
                src = diff[IW-1:0];
                oob = diff[OW] || (diff[OW-1:0] >= EXT_O);
            end
            AG_ROTATE:    src = rot;
            AG_REPLICATE: src = rep;
            AG_TRANSPOSE: src = swap_idx;
            default:      src = idx;
        endcase
    end

endmodule

// File: rtl/strided_addr_gen.sv
// Top of the strided 2D read-address generator.
// Captures mode and parameters on an accepted start, walks the result array and
// registers one linear source address (row*COLS + col) or pad slot per clock.
// Assumes: ROWS*COLS >= 2; parameters lie in the ranges stated per mode.
module strided_addr_gen
    import agen_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 6,
    localparam int IW  = $clog2(((ROWS > COLS) ? ROWS : COLS) + 1),
    localparam int OW  = IW + 1,
    localparam int AGW = $clog2(ROWS * COLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           mode,
    input  logic [IW-1:0]        row_base,
    input  logic [IW-1:0]        col_base,
    input  logic [IW-1:0]        row_stride,
    input  logic [IW-1:0]        col_stride,
    input  logic signed [OW-1:0] row_shift,
    input  logic signed [OW-1:0] col_shift,
    input  logic [IW-1:0]        row_tile,
    input  logic [IW-1:0]        col_tile,
    output logic [AGW-1:0]       addr_out,
    output logic                 addr_valid,
    output logic                 pad_flag,
    output logic                 done
);

    logic [2:0]           cfg_mode;
    logic [IW-1:0]        cfg_rbase, cfg_cbase, cfg_rstride, cfg_cstride;
    logic [IW-1:0]        cfg_rtile, cfg_ctile;
    logic signed [OW-1:0] cfg_rshift, cfg_cshift;

    logic          accept, load, run, flush, row_last, col_last;
    logic [IW-1:0] row_idx, col_idx, row_src, col_src;
    logic          row_oob, col_oob, any_oob;
    logic [AGW-1:0] lin;

    // Capture the run configuration on an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mode    <= '0;
            cfg_rbase   <= '0;
            cfg_cbase   <= '0;
            cfg_rstride <= '0;
            cfg_cstride <= '0;
            cfg_rtile   <= '0;
            cfg_ctile   <= '0;
            cfg_rshift  <= '0;
            cfg_cshift  <= '0;
        end else if (accept) begin
            cfg_mode    <= mode;
            cfg_rbase   <= row_base;
            cfg_cbase   <= col_base;
            cfg_rstride <= row_stride;
            cfg_cstride <= col_stride;
            cfg_rtile   <= row_tile;
            cfg_ctile   <= col_tile;
            cfg_rshift  <= row_shift;
            cfg_cshift  <= col_shift;
        end
    end

    agen_walk #(.ROWS(ROWS), .COLS(COLS), .IW(IW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .swap     (cfg_mode == AG_TRANSPOSE),
        .accept   (accept),
        .load     (load),
        .run      (run),
        .flush    (flush),
        .row_idx  (row_idx),
        .col_idx  (col_idx),
        .row_last (row_last),
        .col_last (col_last)
    );

    agen_axis #(.EXT(ROWS), .IW(IW)) u_row_axis (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_mode),
        .base     (cfg_rbase),
        .stride   (cfg_rstride),
        .tile     (cfg_rtile),
        .ofs      (cfg_rshift),
        .clear    (load),
        .step     (run && col_last && !row_last),
        .idx      (row_idx),
        .swap_idx (col_idx),
        .src      (row_src),
        .oob      (row_oob)
    );

    agen_axis #(.EXT(COLS), .IW(IW)) u_col_axis (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_mode),
        .base     (cfg_cbase),
        .stride   (cfg_cstride),
        .tile     (cfg_ctile),
        .ofs      (cfg_cshift),
        .clear    (load || (run && col_last)),
        .step     (run && !col_last),
        .idx      (col_idx),
        .swap_idx (row_idx),
        .src      (col_src),
        .oob      (col_oob)
    );

    // Form the row-major linear address from the two source indices.
    always_comb begin
        any_oob = row_oob || col_oob;
        lin     = AGW'(row_src) * AGW'(COLS) + AGW'(col_src);
    end

    // Register the output slot; pad slots carry address 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
            pad_flag   <= 1'b0;
            done       <= 1'b0;
        end else begin
            addr_valid <= run;
            pad_flag   <= run && any_oob;
            addr_out   <= (run && !any_oob) ? lin : '0;
            done       <= flush;
        end
    end

endmodule

// File: rtl/agen_check.sv
// Protocol checker for strided_addr_gen, attached by bind below.
// Watches only the output ports and keeps its own count of valid slots per run.
module agen_check #(
    parameter int ROWS = 4,
    parameter int COLS = 6,
    localparam int TOT = ROWS * COLS,
    localparam int AGW = $clog2(TOT),
    localparam int NW  = $clog2(TOT + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AGW-1:0] addr_out,
    input logic           addr_valid,
    input logic           pad_flag,
    input logic           done
);

    logic [NW-1:0] seen;

    // Count valid slots since the last done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || done) seen <= '0;
        else if (addr_valid) seen <= seen + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (addr_out == '0) && !pad_flag); // R1
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid && $past(addr_valid)); // R2
    AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_valid) |-> done); // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen == NW'(TOT))); // R2
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (int'(addr_out) < TOT)); // R3
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pad_flag |-> addr_valid && (addr_out == '0)); // R5
    AST_NO_EXTRA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (seen < NW'(TOT))); // R9

endmodule

bind strided_addr_gen agen_check #(.ROWS(ROWS), .COLS(COLS)) u_agen_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .pad_flag   (pad_flag),
    .done       (done)
);

// File: tb/strided_addr_gen_bench.sv
// Sweeps every transform on a 4 x 6 array and compares each slot against
// arithmetic expectations.
module strided_addr_gen_bench;

    localparam int ROWS = 4;
    localparam int COLS = 6;
    localparam int IW   = $clog2(((ROWS > COLS) ? ROWS : COLS) + 1);
    localparam int OW   = IW + 1;
    localparam int AGW  = $clog2(ROWS * COLS);
    localparam int TOT  = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode = '0;
    logic [IW-1:0] row_base = '0, col_base = '0, row_stride = '0, col_stride = '0;
    logic [IW-1:0] row_tile = '0, col_tile = '0;
    logic signed [OW-1:0] row_shift = '0, col_shift = '0;
    logic [AGW-1:0] addr_out;
    logic addr_valid, pad_flag, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    strided_addr_gen #(.ROWS(ROWS), .COLS(COLS)) u_strided_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .row_base(row_base), .col_base(col_base),
        .row_stride(row_stride), .col_stride(col_stride),
        .row_shift(row_shift), .col_shift(col_shift),
        .row_tile(row_tile), .col_tile(col_tile),
        .addr_out(addr_out), .addr_valid(addr_valid),
        .pad_flag(pad_flag), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(1'b0, "watchdog", cycles, 150000);
            finish_up();
        end
    end

    function automatic int pmod(input int a, input int m);
        return ((a % m) + m) % m;
    endfunction

    // Expected slot k: -1 for pad, else linear address.
    function automatic int expect_slot(input int md, input int k,
                                       input int rb, input int cb, input int rs, input int cs,
                                       input int rm, input int cm, input int rt, input int ct);
        int cl, i, j, r, c;
        bit pad;
        cl  = (md == 4) ? ROWS : COLS;
        i   = k / cl;
        j   = k % cl;
        pad = 1'b0;
        case (md)
            0: begin r = rb + rs * i; c = cb + cs * j; pad = (r >= ROWS) || (c >= COLS); end
            1: begin r = i - rm; c = j - cm; pad = (r < 0) || (r >= ROWS) || (c < 0) || (c >= COLS); end
            2: begin r = pmod(i - rm, ROWS); c = pmod(j - cm, COLS); end
            3: begin r = i % rt; c = j % ct; end
            4: begin r = j; c = i; end
            default: begin r = i; c = j; end
        endcase
        return pad ? -1 : r * COLS + c;
    endfunction

    // One run: program, start, then watch every slot, the done pulse and the tail.
    task automatic run(input int md, input int rb, input int cb, input int rs, input int cs,
                       input int rm, input int cm, input int rt, input int ct,
                       input string req, input bit disturb);
        int first, k, dones, e, got;
        @(negedge clk);
        mode = md[2:0];
        row_base = rb[IW-1:0];   col_base = cb[IW-1:0];
        row_stride = rs[IW-1:0]; col_stride = cs[IW-1:0];
        row_shift = rm[OW-1:0];  col_shift = cm[OW-1:0];
        row_tile = rt[IW-1:0];   col_tile = ct[IW-1:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first = -1; k = 0; dones = 0;
        for (int t = 1; t <= TOT + 8; t++) begin
            @(negedge clk);
            if (disturb && t == 4) begin
                // R9: new start and new settings mid-run
                start = 1'b1; mode = 3'd4;
                row_base = '1; col_stride = '1; row_shift = '1; col_tile = 3'd1;
            end else if (disturb && t == 5) begin
                start = 1'b0;
            end
            if (addr_valid) begin
                if (first < 0) first = t;
                chk(t == first + k, {req, " R2 contiguous valid"}, t, first + k);
                e = expect_slot(md, k, rb, cb, rs, cs, rm, cm, rt, ct);
                got = pad_flag ? -1 : int'(addr_out);
                chk(got == e, {req, " R3 slot address/pad"}, got, e);
                if (pad_flag) chk(addr_out == '0, {req, " R5 pad address"}, int'(addr_out), 0);
                k++;
            end else begin
                chk(addr_out == '0 && !pad_flag, {req, " R1 idle outputs"}, int'(addr_out), 0);
            end
            if (done) begin
                dones++;
                chk(t == first + TOT, {req, " R2 done timing"}, t, first + TOT);
            end
        end
        chk(first == 2, {req, " R2 first valid latency"}, first, 2);
        chk(k == TOT, {req, " R2 slot count"}, k, TOT);
        chk(dones == 1, {req, " R2 single done"}, dones, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!addr_valid && !done && !pad_flag && addr_out == '0, "R1 in reset", int'(addr_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!addr_valid && !done && !pad_flag && addr_out == '0, "R1 after reset", int'(done), 0);

        // R4 section: identity, offsets, zero stride, overflowing strides
        run(0, 0, 0, 1, 1, 0, 0, 1, 1, "R4 section id", 1'b0);
        run(0, 1, 2, 1, 1, 0, 0, 1, 1, "R4 section ofs", 1'b0);
        run(0, 0, 0, 2, 1, 0, 0, 1, 1, "R4 section rstride2", 1'b0);
        run(0, 3, 5, 0, 0, 0, 0, 1, 1, "R4 section stride0", 1'b0);
        run(0, 0, 1, 1, 2, 0, 0, 1, 1, "R4 section cstride2", 1'b0);
        run(0, 7, 7, 7, 7, 0, 0, 1, 1, "R4 section all pad", 1'b0);

        // R5 shift: every row offset against every column offset
        for (int m = -ROWS; m <= ROWS; m++)
            for (int n = -COLS; n <= COLS; n++)
                run(1, 0, 0, 0, 0, m, n, 1, 1, "R5 shift", 1'b0);

        // R6 rotate: all in-range offsets of both signs
        for (int m = -(ROWS-1); m <= ROWS-1; m++)
            for (int n = -(COLS-1); n <= COLS-1; n++)
                run(2, 0, 0, 0, 0, m, n, 1, 1, "R6 rotate", 1'b0);

        // R7 replicate: every tile size
        for (int a = 1; a <= ROWS; a++)
            for (int b = 1; b <= COLS; b++)
                run(3, 0, 0, 0, 0, 0, 0, a, b, "R7 replicate", 1'b0);

        // R8 transpose
        run(4, 0, 0, 0, 0, 0, 0, 1, 1, "R8 transpose", 1'b0);

        // R10 spare codes behave as identity
        for (int md = 5; md <= 7; md++)
            run(md, 3, 3, 3, 3, 2, 2, 2, 2, "R10 spare mode", 1'b0);

        // R9 start and settings changes during a run are ignored
        run(1, 0, 0, 0, 0, 1, -2, 1, 1, "R9 busy shift", 1'b1);
        run(0, 1, 0, 1, 1, 0, 0, 1, 1, "R9 busy section", 1'b1);

        finish_up();
    end

endmodule